// File: doc/BRIEF.md
# FSK Tag Waveform Generator

This block emits an endlessly repeating one-bit sample stream that imitates a low-frequency proximity tag answering a reader field. A 44-bit identifier is turned into a frame of frequency-shift-keyed groups. A slow-carrier group is six periods of a high-2/low-6 pattern (48 samples). A fast-carrier group is five periods of a high-3/low-7 pattern (50 samples). Each identifier bit is a pair of groups whose order gives its value, in the way Manchester coding does. A slow group is placed ahead of every four bits. The frame opens with a marker built from group pairs that no data bit can produce.

The surrounding logic supplies a sample strobe at the wanted sample rate and holds a level `run` input high for as long as the tag should answer. While the generator is idle, a new identifier can be written. Every frame is 5232 samples long: 392 for the marker, 528 for the eleven separator groups and 4312 for the 44 bit pairs.

Top module: `fsk_tag_gen`

## Requirements
- R1: While `run` was low at the previous clock edge, `dout` is 0 whatever `sample_en` does.
- R2: A slow group is 48 samples: the 8-sample pattern 1,1,0,0,0,0,0,0, six times over.
- R3: A fast group is 50 samples: the 10-sample pattern 1,1,1,0,0,0,0,0,0,0, five times over.
- R4: Identifier bits go out from bit 43 down to bit 0. A 1 is a fast group then a slow group. A 0 is a slow group then a fast group.
- R5: One extra slow group comes before bits 43, 39, 35, and so on down to bit 3.
- R6: Each frame opens with the marker slow, slow, slow, fast, fast, fast, slow, fast.
- R7: After the last group of bit 0, the marker of the next frame follows at once. Each frame is 5232 samples long.
- R8: The first sample of a frame is on `dout` in the cycle after `run` is first seen high. The stream moves on by exactly one sample at each clock edge where both `sample_en` and the active state are high. Otherwise `dout` holds.
- R9: `id_load` captures `id_in` only while the generator is idle. A load in the same cycle that `run` rises is taken and used for the first frame. A load while active is ignored.
- R10: When `run` drops, the generator goes idle. The next start begins again at the first sample of the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Level that enables the generator |
| sample_en | input | 1 | Advance to the next sample |
| id_load | input | 1 | Capture `id_in` while idle |
| id_in | input | 44 | Identifier to be sent |
| dout | output | 1 | Current waveform sample |

## Verification
The collision that matters is a write of a new identifier in the same cycle that `run` rises. The write must still be taken, and the first frame must carry the new value. The bench forces this after a mid-frame stop: it raises `id_load` and `run` on the same edge, and checks every sample of the next frame against one built from the new identifier. A second collision is a load pulse issued while the stream is advancing. The bench judges it by showing that the following frame still carries the old identifier.

// File: rtl/fsk_tag_gen.sv
module fsk_tag_gen #(
  parameter int ID_W  = 44,
  parameter int NIB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            sample_en,
  input  logic            id_load,
  input  logic [ID_W-1:0] id_in,
  output logic            dout
);

  localparam int BI_W = $clog2(ID_W);
  localparam int SLOW_LEN = 48;
  localparam int FAST_LEN = 50;
  localparam int FRAME_LEN = 4*SLOW_LEN + 4*FAST_LEN + (ID_W/NIB_W)*SLOW_LEN
                           + ID_W*(SLOW_LEN + FAST_LEN);
  localparam int SC_W = $clog2(FRAME_LEN);
  localparam logic [7:0] MARK_FAST = 8'b1011_1000;

  logic            active;
  logic [ID_W-1:0] id_reg;
  logic            in_mark, sep, half;
  logic [2:0]      mk;
  logic [BI_W-1:0] bidx;
  logic [3:0]      ph;
  logic [2:0]      rep;

  logic fast, grp_end, adv;

  assign fast    = in_mark ? MARK_FAST[mk] : (!sep && (id_reg[bidx] ^ half));
  assign grp_end = (ph == (fast ? 4'd9 : 4'd7)) && (rep == (fast ? 3'd4 : 3'd5));
  assign adv     = active && sample_en;
  assign dout    = active && (ph < (fast ? 4'd3 : 4'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      id_reg <= '0;
    end else begin
      active <= run;
      if (!active && id_load) id_reg <= id_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mark <= 1'b1;
      mk      <= '0;
      sep     <= 1'b0;
      half    <= 1'b0;
      bidx    <= BI_W'(ID_W-1);
      ph      <= '0;
      rep     <= '0;
    end else if (!active) begin
      in_mark <= 1'b1;
      mk      <= '0;
      sep     <= 1'b0;
      half    <= 1'b0;
      bidx    <= BI_W'(ID_W-1);
      ph      <= '0;
      rep     <= '0;
    end else if (adv) begin
      if (!grp_end) begin
        if (ph == (fast ? 4'd9 : 4'd7)) begin
          ph  <= '0;
          rep <= rep + 3'd1;
        end else begin
          ph <= ph + 4'd1;
        end
      end else begin
        ph  <= '0;
        rep <= '0;
        if (in_mark) begin
          if (mk == 3'd7) begin
            in_mark <= 1'b0;
            sep     <= 1'b1;
            bidx    <= BI_W'(ID_W-1);
          end else begin
            mk <= mk + 3'd1;
          end
        end else if (sep) begin
          sep  <= 1'b0;
          half <= 1'b0;
        end else if (!half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          if (bidx == '0) begin
            in_mark <= 1'b1;
            mk      <= '0;
          end else begin
            bidx <= bidx - BI_W'(1);
            if ((int'(bidx) % NIB_W) == 0) sep <= 1'b1;
          end
        end
      end
    end
  end

  logic [SC_W-1:0] sc;
  logic            frame_wrap;
  assign frame_wrap = adv && grp_end && !in_mark && !sep && half && (bidx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sc <= '0;
    else if (!active)     sc <= '0;
    else if (frame_wrap)  sc <= '0;
    else if (adv)         sc <= sc + SC_W'(1);
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !dout);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(sample_en)) |-> $stable(dout));

  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> (sc == SC_W'(FRAME_LEN-1)));

  assert_id_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(id_reg));

  assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bidx) < ID_W);

endmodule

// File: tb/fsk_tag_gen_tb.sv
module fsk_tag_gen_tb;
  localparam int ID_W = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic sample_en = 1'b0;
  logic id_load = 1'b0;
  logic [ID_W-1:0] id_in = '0;
  logic dout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct { logic b; string req; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fsk_tag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_en(sample_en),
    .id_load(id_load), .id_in(id_in), .dout(dout)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic push_grp(input bit is_fast, input string req);
    for (int r = 0; r < (is_fast ? 5 : 6); r++)
      for (int p = 0; p < (is_fast ? 10 : 8); p++)
        q.push_back('{b: (p < (is_fast ? 3 : 2)), req: req});
  endtask

  task automatic push_frame(input logic [ID_W-1:0] id, input string ovr);
    bit mark [8] = '{0, 0, 0, 1, 1, 1, 0, 1};
    for (int m = 0; m < 8; m++)
      push_grp(mark[m], ovr != "" ? ovr : (mark[m] ? "R6/R3" : "R6/R2"));
    for (int b = ID_W-1; b >= 0; b--) begin
      if (b % 4 == 3) push_grp(1'b0, ovr != "" ? ovr : "R5");
      push_grp(id[b], ovr != "" ? ovr : "R4");
      push_grp(!id[b], ovr != "" ? ovr : "R4");
    end
  endtask

  // monitor step: compare current sample against the scoreboard head
  task automatic step(input bit adv);
    exp_t e;
    @(negedge clk);
    id_load = 1'b0;
    e = q[0];
    check(dout, e.b, adv ? e.req : "R8");
    if (adv) void'(q.pop_front());
    sample_en = adv;
  endtask

  localparam logic [ID_W-1:0] ID_A = 44'hA5C3F0196E2;
  localparam logic [ID_W-1:0] ID_B = 44'h0F1E2D3C4B5;

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sample_en = 1'b1;
      check(dout, 1'b0, "R1");
    end
    sample_en = 1'b0;
    id_in = ID_A; id_load = 1'b1;
    @(negedge clk);
    id_load = 1'b0;
    run = 1'b1;
    push_frame(ID_A, "");
    push_frame(ID_A, "R7");
    for (int k = 0; k < 2*5232; k++) begin
      if (k % 97 == 13) step(1'b0);
      step(1'b1);
      if (k == 2000) begin id_in = ID_B; id_load = 1'b1; end
    end
    for (int k = 0; k < 700; k++) begin
      push_grp(1'b0, "R7");
      if (k == 0) break;
    end
    for (int k = 0; k < 40; k++) step(1'b1);
    @(negedge clk);
    run = 1'b0; sample_en = 1'b0; q.delete();
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sample_en = 1'b1;
      check(dout, 1'b0, "R10");
    end
    sample_en = 1'b0;
    id_in = ID_B; id_load = 1'b1; run = 1'b1;
    push_frame(ID_B, "R9/R10");
    push_frame(ID_B, "");
    for (int k = 0; k < 5232 + 300; k++) step(1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule